// File: doc/BRIEF.md
# DMA Event Enable and Pending Gate

This block sits between the external synchronization event lines of a DMA engine and the unit that issues transfer requests. A rising edge on any of the event lines is captured in a per-event pending register. A per-event enable register decides whether a captured event may become a transfer trigger. Software cannot write the enable register directly. It sets enable bits through a write-1-to-set register and clears them through a write-1-to-clear register, over a simple single-cycle register bus.

An event that is captured while its enable bit is 0 is not lost. It stays pending and fires as soon as software enables it. Two further trigger sources skip the enable gate: a software manual-set register and a chained-event input driven by transfer completion logic. Eligible triggers are issued one per cycle, lowest event number first, with a valid/ready handshake toward the downstream issuer. Issuing a trigger retires the matching pending bits.

Top module: `dma_evt_gate`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, and `trig_valid_o` is 0.
- R2: Register word addresses on `bus_addr_i`: 0 enable (read-only), 1 enable-set, 2 enable-clear, 3 event pending (read-only), 4 pending-clear, 5 manual-set. A write to address 0 leaves the enable register unchanged. Bits 31:20 of every read are 0. Reads of addresses 1, 2, 4 and 5 return 0.
- R3: A write to address 1 sets every enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R4: A write to address 2 clears every enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R5: A rising edge on `evt_i[n]` sets pending bit n whether or not enable bit n is set. If the line stays high, the pending bit is not set again.
- R6: While enable bit n is 0, pending bit n produces no trigger and stays set.
- R7: If enable bit n becomes 1 while pending bit n is set, event n is issued as a trigger.
- R8: A write to address 5 with data bit n at 1 produces a trigger for event n even when enable bit n is 0.
- R9: A cycle with `chain_evt_i[n]` high produces a trigger for event n even when enable bit n is 0.
- R10: When several events are eligible, `trig_id_o` is the lowest eligible event number. One trigger is issued per cycle in which `trig_valid_o` and `trig_ready_i` are both 1. While `trig_ready_i` is 0, the trigger is held.
- R11: Issuing a trigger for event n clears pending bit n and the bypass request for n.
- R12: A write to address 4 clears every pending bit whose data bit is 1. A cleared event does not fire when it is enabled later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| evt_i | input | 20 | External synchronization event lines |
| chain_evt_i | input | 20 | Chained trigger requests, one cycle each |
| trig_valid_o | output | 1 | A trigger is offered |
| trig_id_o | output | 5 | Event number of the offered trigger |
| trig_ready_i | input | 1 | The downstream issuer accepts the trigger |

## Verification
The assertions assume one register access per cycle. This means a set and a clear of the same enable bit never happen in the same cycle. The assertions also assume that `evt_i` is synchronous to `clk_i`. The stimulus drives every input shortly after a rising edge, keeps the write strobe to one cycle per access, and pulses `chain_evt_i` for exactly one cycle. It holds `trig_ready_i` low only across a deliberate back-pressure window, so that the ordering of the queued triggers can be observed.

// File: rtl/dma_evt_gate_pkg.sv
package dma_evt_gate_pkg;
  typedef enum logic [2:0] {
    REG_EN       = 3'd0,
    REG_EN_SET   = 3'd1,
    REG_EN_CLR   = 3'd2,
    REG_PEND     = 3'd3,
    REG_PEND_CLR = 3'd4,
    REG_MAN_SET  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/evg_enable.sv
module evg_enable #(
  parameter int N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_o <= '0;
    else         en_o <= (en_o | set_i) & ~clr_i;  // clear wins

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((en_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((en_o & $past(clr_i)) == '0));
endmodule

// File: rtl/evg_pend.sv
module evg_pend #(
  parameter int N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] man_set_i,
  input  logic [N-1:0] chain_i,
  input  logic [N-1:0] issue_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] byp_o
);
  logic [N-1:0] evt_q, rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      evt_q  <= '0;
      pend_o <= '0;
      byp_o  <= '0;
    end else begin
      evt_q  <= evt_i;
      // a new edge survives a same-cycle clear or issue
      pend_o <= (pend_o & ~sw_clr_i & ~issue_i) | rise;
      byp_o  <= (byp_o & ~issue_i) | man_set_i | chain_i;
    end

  assert_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_o & $past(rise)) == $past(rise)));
  assert_issue_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|issue_i) |=> ((pend_o & $past(issue_i & ~rise)) == '0));
  assert_byp_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|issue_i) |=> ((byp_o & $past(issue_i & ~man_set_i & ~chain_i)) == '0));
endmodule

// File: rtl/evg_arb.sv
module evg_arb #(
  parameter int N   = 20,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) id_o = IDW'(i);
  end
  assign valid_o = |req_i;

  assert_pick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[id_o]);
  assert_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((req_i & ((N'(1) << id_o) - N'(1))) == '0));
endmodule

// File: rtl/dma_evt_gate.sv
module dma_evt_gate
  import dma_evt_gate_pkg::*;
#(
  parameter int N   = 20,
  parameter int DW  = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_we_i,
  input  logic [2:0]     bus_addr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  input  logic [N-1:0]   evt_i,
  input  logic [N-1:0]   chain_evt_i,
  output logic           trig_valid_o,
  output logic [IDW-1:0] trig_id_o,
  input  logic           trig_ready_i
);
  logic [N-1:0] wbits, en_set, en_clr, pend_clr, man_set;
  logic [N-1:0] en, pend, byp, req, issue;
  logic         fire;

  assign wbits    = bus_wdata_i[N-1:0];
  assign en_set   = (bus_we_i && bus_addr_i == REG_EN_SET)   ? wbits : '0;
  assign en_clr   = (bus_we_i && bus_addr_i == REG_EN_CLR)   ? wbits : '0;
  assign pend_clr = (bus_we_i && bus_addr_i == REG_PEND_CLR) ? wbits : '0;
  assign man_set  = (bus_we_i && bus_addr_i == REG_MAN_SET)  ? wbits : '0;

  always_comb begin
    case (bus_addr_i)
      REG_EN:   bus_rdata_o = DW'(en);
      REG_PEND: bus_rdata_o = DW'(pend);
      default:  bus_rdata_o = '0;
    endcase
  end

  evg_enable #(.N(N)) u_enable (
    .clk_i, .rst_ni, .set_i(en_set), .clr_i(en_clr), .en_o(en)
  );

  evg_pend #(.N(N)) u_pend (
    .clk_i, .rst_ni, .evt_i, .sw_clr_i(pend_clr), .man_set_i(man_set),
    .chain_i(chain_evt_i), .issue_i(issue), .pend_o(pend), .byp_o(byp)
  );

  assign req = (pend & en) | byp;  // bypass sources ignore the enable

  evg_arb #(.N(N), .IDW(IDW)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .valid_o(trig_valid_o), .id_o(trig_id_o)
  );

  assign fire = trig_valid_o & trig_ready_i;
  always_comb begin
    issue = '0;
    if (fire) issue[trig_id_o] = 1'b1;
  end

  assert_en_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_EN) |=> $stable(en));
  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_o && !byp[trig_id_o]) |-> en[trig_id_o]);
endmodule

// File: tb/dma_evt_gate_tb_top.sv
module dma_evt_gate_tb_top;
  localparam int N = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] evt = '0, chain = '0;
  logic        valid, ready = 1'b0;
  logic [4:0]  id;

  int vectors = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_evt_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
    .chain_evt_i(chain), .trig_valid_o(valid), .trig_id_o(id),
    .trig_ready_i(ready)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_trig(int n, string tag);
    exp_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, int exp, string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected trigger: actual id %0d expected none", id);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != int'(id)) begin
          errors++;
          $display("FAIL %s: actual id %0d expected %0d", t, id, e);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    rd(3'd0, 0, "R1 enable");
    rd(3'd3, 0, "R1 pending");
    chk("R1 valid", valid, 0);
    // R3, R2, R4
    wr(3'd1, 32'h5);        rd(3'd0, 32'h5, "R3 set");
    wr(3'd1, 32'h0);        rd(3'd0, 32'h5, "R3 zero write");
    wr(3'd0, 32'hFFFFF);    rd(3'd0, 32'h5, "R2 direct write");
    wr(3'd1, 32'hFFFFFFFF); rd(3'd0, 32'hFFFFF, "R2 reserved bits");
    rd(3'd1, 0, "R2 set reg reads zero");
    wr(3'd2, 32'hFFFF0);    rd(3'd0, 32'hF, "R4 clear");
    wr(3'd2, 32'h0);        rd(3'd0, 32'hF, "R4 zero write");
    ready = 1'b1;
    // R5 enabled event
    expect_trig(2, "R5 enabled edge");
    evt[2] = 1'b1; cyc(1); evt[2] = 1'b0; cyc(4);
    rd(3'd3, 0, "R11 pending retired");
    // R6 disabled event held, R7 fires on enable
    evt[7] = 1'b1; cyc(1); evt[7] = 1'b0; cyc(4);
    rd(3'd3, 32'h80, "R6 pending held");
    chk("R6 no trigger", valid, 0);
    expect_trig(7, "R7 late enable");
    wr(3'd1, 32'h80); cyc(3);
    rd(3'd3, 0, "R11 pending after late fire");
    // R8 / R9 bypass with all disabled
    wr(3'd2, 32'hFFFFF);
    expect_trig(9, "R8 manual set");
    wr(3'd5, 32'h200); cyc(3);
    expect_trig(12, "R9 chained");
    chain[12] = 1'b1; cyc(1); chain[12] = 1'b0; cyc(3);
    // R10 priority under back-pressure
    ready = 1'b0;
    wr(3'd1, 32'hFFFFF);
    evt[15] = 1'b1; evt[3] = 1'b1; evt[10] = 1'b1; cyc(1);
    evt = '0; cyc(3);
    chk("R10 valid held", valid, 1);
    chk("R10 lowest id", id, 3);
    expect_trig(3, "R10 order 1");
    expect_trig(10, "R10 order 2");
    expect_trig(15, "R10 order 3");
    ready = 1'b1; cyc(5);
    // R5 held level triggers once
    expect_trig(4, "R5 level held");
    evt[4] = 1'b1; cyc(10); evt[4] = 1'b0; cyc(3);
    // R12 software pending clear
    wr(3'd2, 32'h40);
    evt[6] = 1'b1; cyc(1); evt[6] = 1'b0; cyc(3);
    rd(3'd3, 32'h40, "R12 pending before clear");
    wr(3'd4, 32'h40);
    rd(3'd3, 0, "R12 pending cleared");
    wr(3'd1, 32'h40); cyc(5);
    chk("R12 no late trigger", valid, 0);
    chk("scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule